// File: doc/BRIEF.md
# Clock Pulse Skipping Throttler

This block lowers the effective frequency of a clock domain by removing a set share of its clock pulses. The clock is not divided. The block drives a pulse-enable line, and a clock gate cell outside the block uses that line to let each incoming pulse through or hold it back. The throttle depth is the number of pulses held back out of every window of 100 cycles.

The depth comes from one of two inputs, chosen by a mode select. In percentage mode the depth is a number from 0 to 100. In level mode a two-bit code picks one of four fixed depths. The skipped pulses are spread across the window by a modulo-100 accumulator, so they do not come in bursts. The depth for a window is captured in the window's first cycle and stays fixed until the next window starts. A change in the middle of a window therefore never leaves that window with a count that is neither the old depth nor the new one.

Top module: `pulse_skip_throttle`

## Requirements
- R1: While reset is asserted, `pulse_en` is 1 (no throttling). The first window starts at the first rising clock edge after reset is released.
- R2: `pulse_en` is a registered output. It reports the decision for window position k (0..99) one cycle after the clock edge that processed that position. Over each window of 100 positions, exactly D pulses are suppressed, where D is the window's depth.
- R3: Position k of a window with depth D is suppressed exactly when floor((k+1)·D/100) > floor(k·D/100). As a result, two suppressed pulses are never adjacent when D ≤ 50.
- R4: A depth of 100 suppresses every pulse of the window. A depth of 0 passes every pulse.
- R5: In percentage mode, a `depth_pct` value above 100 is treated as 100.
- R6: When `pct_mode` = 0 (level mode), `level_code` values 0, 1, 2 and 3 select depths of 0, 50, 75 and 85.
- R7: When `pct_mode` = 1, the depth is `depth_pct` and `level_code` has no effect. When `pct_mode` = 0, `depth_pct` has no effect.
- R8: The depth inputs and the mode are sampled only on the first position (k = 0) of each window. Changes at any other position have no effect until the next window starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock whose pulses are throttled |
| rst_n | input | 1 | Active-low asynchronous reset |
| depth_pct | input | 7 | Percentage depth (0..100; larger values are clamped) |
| level_code | input | 2 | Level-mode depth code |
| pct_mode | input | 1 | 1 selects percentage depth, 0 selects level code |
| pulse_en | output | 1 | 1 lets the current clock pulse pass, 0 suppresses it |

## Verification
Two functions can fall in the same cycle: capturing a new depth at a window wrap, and ignoring depth changes in the middle of a window. The bench provokes both in every window. It drives a new depth, level and mode on the wrap cycle (k = 0), then scrambles all three again at k = 50. Each position's output is then judged against the arithmetic rule for the depth captured at the wrap, and each window's total skip count is compared with that same depth.

// File: rtl/thr_pkg.sv
package thr_pkg;
    localparam int WINDOW  = 100;
    localparam int PCT_W   = 7;
    localparam int LVL_W   = 2;
    localparam int SUM_W   = PCT_W + 1;

    typedef logic [PCT_W-1:0] depth_t;

    typedef struct packed {
        logic [PCT_W-1:0] phase;
        logic [PCT_W-1:0] acc;
        depth_t           act;
        logic             en;
    } accum_state_t;
endpackage

// File: rtl/thr_depth_map.sv
module thr_depth_map
    import thr_pkg::*;
#(
    parameter int LVL1_PCT = 50,
    parameter int LVL2_PCT = 75,
    parameter int LVL3_PCT = 85
) (
    input  logic [PCT_W-1:0] depth_pct,
    input  logic [LVL_W-1:0] level_code,
    input  logic             pct_mode,
    output depth_t           depth_sel
);
    localparam depth_t WIN_D = depth_t'(WINDOW);

    depth_t lvl_depth;
    depth_t pct_clamped;

    always_comb begin
        unique case (level_code)
            2'd0:    lvl_depth = '0;
            2'd1:    lvl_depth = depth_t'(LVL1_PCT);
            2'd2:    lvl_depth = depth_t'(LVL2_PCT);
            default: lvl_depth = depth_t'(LVL3_PCT);
        endcase
    end

    always_comb begin
        pct_clamped = (depth_pct > WIN_D) ? WIN_D : depth_pct;
        depth_sel   = pct_mode ? pct_clamped : lvl_depth;
    end
endmodule

// File: rtl/thr_skip_accum.sv
module thr_skip_accum
    import thr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  depth_t           depth_in,
    output logic             pulse_en,
    output logic [PCT_W-1:0] phase_o,
    output depth_t           act_o
);
    localparam logic [PCT_W-1:0] LAST_POS = (PCT_W)'(WINDOW - 1);
    localparam logic [SUM_W-1:0] WIN_S    = (SUM_W)'(WINDOW);

    accum_state_t st_q, st_d;
    depth_t           eff_depth;
    logic [SUM_W-1:0] sum;
    logic             skip;

    always_comb begin
        st_d      = st_q;
        eff_depth = (st_q.phase == '0) ? depth_in : st_q.act;
        sum       = {1'b0, st_q.acc} + {1'b0, eff_depth};
        skip      = (sum >= WIN_S);
        st_d.act  = eff_depth;
        st_d.acc  = skip ? (PCT_W)'(sum - WIN_S) : sum[PCT_W-1:0];
        st_d.phase = (st_q.phase == LAST_POS) ? '0 : st_q.phase + 1'b1;
        st_d.en   = ~skip;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase <= '0;
            st_q.acc   <= '0;
            st_q.act   <= '0;
            st_q.en    <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign pulse_en = st_q.en;
    assign phase_o  = st_q.phase;
    assign act_o    = st_q.act;
endmodule

// File: rtl/pulse_skip_throttle.sv
module pulse_skip_throttle
    import thr_pkg::*;
#(
    parameter int LVL1_PCT = 50,
    parameter int LVL2_PCT = 75,
    parameter int LVL3_PCT = 85
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PCT_W-1:0] depth_pct,
    input  logic [LVL_W-1:0] level_code,
    input  logic             pct_mode,
    output logic             pulse_en
);
    depth_t           depth_sel_w;
    logic [PCT_W-1:0] phase_w;
    depth_t           act_w;

    thr_depth_map #(
        .LVL1_PCT (LVL1_PCT),
        .LVL2_PCT (LVL2_PCT),
        .LVL3_PCT (LVL3_PCT)
    ) map_i (
        .depth_pct  (depth_pct),
        .level_code (level_code),
        .pct_mode   (pct_mode),
        .depth_sel  (depth_sel_w)
    );

    thr_skip_accum accum_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .depth_in (depth_sel_w),
        .pulse_en (pulse_en),
        .phase_o  (phase_w),
        .act_o    (act_w)
    );
endmodule

// File: rtl/thr_checker.sv
module thr_checker
    import thr_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             pulse_en,
    input logic [PCT_W-1:0] phase,
    input depth_t           act,
    input depth_t           sel
);
    logic [PCT_W:0] skip_cnt;
    depth_t         win_d;
    logic           seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            skip_cnt <= '0;
            win_d    <= '0;
            seen     <= 1'b0;
        end else if (phase == (PCT_W)'(1)) begin
            skip_cnt <= {{PCT_W{1'b0}}, ~pulse_en};
            win_d    <= act;
            seen     <= 1'b1;
        end else begin
            skip_cnt <= skip_cnt + {{PCT_W{1'b0}}, ~pulse_en};
        end
    end

    // R2: the total skipped over a completed window equals its depth
    a_r2_window_count: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == (PCT_W)'(1) && seen) |-> (skip_cnt == {1'b0, win_d}));

    // R1: the position counter stays inside the window
    a_r1_phase_range: assert property (@(posedge clk) disable iff (!rst_n)
        phase < (PCT_W)'(WINDOW));

    // R4: a full-depth window suppresses its first pulse
    a_r4_full_depth: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == '0 && sel == depth_t'(WINDOW)) |=> !pulse_en);

    // R4: a zero-depth window passes its first pulse
    a_r4_zero_depth: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == '0 && sel == '0) |=> pulse_en);

    // R3: no adjacent skips for shallow depths within a window
    a_r3_no_adjacent: assert property (@(posedge clk) disable iff (!rst_n)
        (!pulse_en && act <= depth_t'(WINDOW / 2) && phase != '0) |=> pulse_en);

    // R8: the window depth holds between wraps
    a_r8_depth_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != '0) |=> (phase == (PCT_W)'(1) || $stable(act)));
endmodule

bind pulse_skip_throttle thr_checker chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .pulse_en (pulse_en),
    .phase    (phase_w),
    .act      (act_w),
    .sel      (depth_sel_w)
);

// File: tb/pulse_skip_throttle_tb.sv
module pulse_skip_throttle_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] depth_pct = '0;
    logic [1:0] level_code = '0;
    logic       pct_mode = 1'b1;
    logic       pulse_en;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    pulse_skip_throttle dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .depth_pct  (depth_pct),
        .level_code (level_code),
        .pct_mode   (pct_mode),
        .pulse_en   (pulse_en)
    );

    function automatic bit exp_skip(int k, int d);
        return (((k + 1) * d) / 100) > ((k * d) / 100);
    endfunction

    task automatic chk(bit cond, string req, int act, int exp);
        checks++;
        if (!cond) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Runs one window; inputs given are applied at k=0, scrambled at k=50.
    task automatic run_window(int pct, int lvl, bit mode, int d_exp, string req);
        int cnt = 0;
        for (int k = 0; k < 100; k++) begin
            if (k == 0) begin
                depth_pct  = 7'(pct);
                level_code = 2'(lvl);
                pct_mode   = mode;
            end else if (k == 50) begin
                depth_pct  = 7'((pct + 37) % 128);   // R8: ignored mid-window
                level_code = 2'(lvl + 1);
                pct_mode   = ~mode;
            end
            @(posedge clk);
            #5;
            if (!pulse_en) cnt++;
            chk(pulse_en == !exp_skip(k, d_exp), req, int'(pulse_en),
                int'(!exp_skip(k, d_exp)));
            @(negedge clk);
        end
        chk(cnt == d_exp, "R2 window count", cnt, d_exp);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(pulse_en == 1'b1, "R1 reset enable", int'(pulse_en), 1);
        rst_n = 1'b1;
        // R2 R3 R4 R7 R8: full percentage sweep, level code set but unused
        for (int d = 0; d <= 100; d++) begin
            string tag;
            tag = (d == 0 || d == 100) ? "R4 edge depth" : "R3 pct spread";
            run_window(d, 3, 1'b1, d, tag);
        end
        // R6 R7: level mode, percentage input set but unused
        run_window(13, 0, 1'b0, 0,  "R6 level 0");
        run_window(13, 1, 1'b0, 50, "R6 level 1");
        run_window(99, 2, 1'b0, 75, "R6 level 2");
        run_window(5,  3, 1'b0, 85, "R6 level 3");
        // R5: out-of-range percentages clamp to full depth
        run_window(127, 1, 1'b1, 100, "R5 clamp 127");
        run_window(101, 0, 1'b1, 100, "R5 clamp 101");
        run_window(30, 2, 1'b1, 30, "R8 after clamp");
        // R1: reset mid-window restores pass-through and restarts window
        rst_n = 1'b0;
        #5;
        chk(pulse_en == 1'b1, "R1 reset mid-run", int'(pulse_en), 1);
        @(negedge clk);
        rst_n = 1'b1;
        run_window(50, 0, 1'b1, 50, "R1 restart window");
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule